// File: doc/BRIEF.md
# Asynchronous DRAM Cycle-Type Decoder

This block watches the control strobes of an asynchronous page-mode DRAM (row strobe, two byte-lane column strobes, write enable and output enable, all active low) on a fast sampling clock. It names every memory cycle as one of eight kinds: read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh, hidden refresh or self-refresh. It does this only from the order in which the strobes move; no address or data is looked at.

At the end of each row-strobe low period it gives a one-cycle report with a 3-bit cycle code and a 2-bit byte-lane mask. It keeps a row counter that advances on each refresh that takes its row from inside the device. It also shows when the device would drive its data pins, including read data held over a hidden refresh. It serves as a protocol monitor, or as the control front of a behavioural memory model.

Strobes are taken as already synchronous to `clk_i`. A strobe change is seen at the first rising clock edge after it happens.

Top module: `dram_cyc_decoder`

## Requirements
- R1: After reset `cyc_valid_o`, `self_ref_o` and `dq_drive_o` are 0 and `ref_row_o` is 0.
- R2: A row-strobe low period in which a column strobe falls, with write enable high throughout, is reported as code 0 (read). The report comes one cycle after the edge that samples the row strobe high, and `ref_row_o` does not change.
- R3: If write enable is low at the sample where a column strobe is first seen low, the cycle is code 1 (early write), and `dq_drive_o` stays 0 for the whole cycle.
- R4: If write enable falls after the column strobe, the cycle is code 2 (late write) when output enable was high at every earlier column-active sample. It is code 3 (read-modify-write) when output enable was seen low at such a sample before write enable fell.
- R5: A row-strobe low period with both column strobes high at its start and with no column strobe falling is code 4 (row-only refresh). Its lane mask is 0 and `ref_row_o` does not change.
- R6: If a column strobe is low when the row strobe falls, and no read data is being held, the cycle is code 5 (column-before-row refresh). `ref_row_o` increases by one in the same cycle as the report.
- R7: If the row strobe falls while a column strobe is still low from a read cycle that ended with that strobe low, the cycle is code 6 (hidden refresh). `ref_row_o` increases by one, and `dq_drive_o` stays 1 for the whole refresh while output enable is low and write enable is high.
- R8: If the row strobe stays low for SELF_CYC further samples after a column-first refresh starts, `self_ref_o` rises after that sample. The cycle is then reported as code 7 (self-refresh) and `ref_row_o` increases by one. One sample fewer gives code 5, and `self_ref_o` never rises.
- R9: `dq_drive_o` is 1 while a read or read-modify-write cycle has a column strobe low, output enable low and write enable high. It stays 1 past the rise of the row strobe while the column strobe stays low. It drops one sample after both column strobes are high, after output enable goes high, or after write enable falls.
- R10: `cyc_valid_o` is high for exactly one cycle per row-strobe low period.
- R11: Lane mask bit 0 stands for the lower-byte column strobe and bit 1 for the upper-byte strobe. For access cycles the mask is the OR of the strobes seen low while the row strobe is low. For refresh cycles it is the strobes low at the row-strobe fall.
- R12: `ref_row_o` wraps from 2^ROW_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Lower-byte column strobe, active low |
| cash_ni | input | 1 | Upper-byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| cyc_valid_o | output | 1 | One-cycle report pulse |
| cyc_type_o | output | 3 | Cycle code (0 to 7 as in R2 to R8) |
| lane_mask_o | output | 2 | Byte lanes of the reported cycle |
| ref_row_o | output | ROW_W | Next row for internal refresh |
| self_ref_o | output | 1 | Self-refresh in progress |
| dq_drive_o | output | 1 | Device would drive its data pins |

## Verification
The bench builds the block with SELF_CYC set to 16 instead of the default of 20000. This puts the self-refresh entry boundary, at 16 and 17 low samples, within a few cycles. It keeps ROW_W at its default of 10, so a run of 1024 short refreshes walks the row counter through its wrap. Random cycle kinds with random lane masks and random gaps between strobes are mixed with directed hidden-refresh and self-refresh sequences.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [2:0] {
    CYC_READ     = 3'd0,
    CYC_EARLY_WR = 3'd1,
    CYC_LATE_WR  = 3'd2,
    CYC_RMW      = 3'd3,
    CYC_RAS_ONLY = 3'd4,
    CYC_CBR      = 3'd5,
    CYC_HIDDEN   = 3'd6,
    CYC_SELF     = 3'd7
  } cyc_type_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_REF, ST_SELF
  } fsm_st_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/dram_strobe_front.sv
module dram_strobe_front
  import dram_cyc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             casl_ni,
  input  logic             cash_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  output logic             ras_fall_o,
  output logic             ras_rise_o,
  output logic             cas_low_o,
  output logic [LANES-1:0] lanes_o,
  output logic             we_low_o,
  output logic             oe_low_o
);
  logic ras_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_q <= 1'b1;
    else         ras_q <= ras_ni;
  end

  assign ras_fall_o = ras_q & ~ras_ni;
  assign ras_rise_o = ~ras_q & ras_ni;
  assign lanes_o    = {~cash_ni, ~casl_ni};
  assign cas_low_o  = |lanes_o;
  assign we_low_o   = ~we_ni;
  assign oe_low_o   = ~oe_ni;
endmodule

// File: rtl/dram_cyc_fsm.sv
module dram_cyc_fsm
  import dram_cyc_pkg::*;
#(
  parameter int unsigned SELF_CYC = 20000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_fall_i,
  input  logic             ras_rise_i,
  input  logic             cas_low_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic             we_low_i,
  input  logic             oe_low_i,
  output logic             valid_o,
  output cyc_type_e        type_o,
  output logic [LANES-1:0] mask_o,
  output logic             ref_step_o,
  output logic             self_ref_o,
  output logic             drive_o
);
  localparam int unsigned CNT_W = $clog2(SELF_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SELF_CYC - 1);

  fsm_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] lanes_q;
  logic early_q, late_q, rmw_q, oe_seen_q, hidden_q, hold_q;
  cyc_type_e acc_type;

  always_comb begin
    if (early_q)     acc_type = CYC_EARLY_WR;
    else if (rmw_q)  acc_type = CYC_RMW;
    else if (late_q) acc_type = CYC_LATE_WR;
    else             acc_type = CYC_READ;
  end

  assign ref_step_o = ras_rise_i & (st_q == ST_REF || st_q == ST_SELF);
  assign self_ref_o = (st_q == ST_SELF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      lanes_q   <= '0;
      early_q   <= 1'b0;
      late_q    <= 1'b0;
      rmw_q     <= 1'b0;
      oe_seen_q <= 1'b0;
      hidden_q  <= 1'b0;
      valid_o   <= 1'b0;
      type_o    <= CYC_READ;
      mask_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (ras_fall_i) begin
          lanes_q <= lanes_i;
          cnt_q   <= '0;
          if (cas_low_i) begin
            st_q     <= ST_REF;
            hidden_q <= hold_q;
          end else begin
            st_q <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (ras_rise_i) begin
            valid_o <= 1'b1;
            type_o  <= CYC_RAS_ONLY;
            mask_o  <= '0;
            st_q    <= ST_IDLE;
          end else if (cas_low_i) begin
            lanes_q   <= lanes_q | lanes_i;
            st_q      <= ST_COL;
            early_q   <= we_low_i;
            late_q    <= 1'b0;
            rmw_q     <= 1'b0;
            oe_seen_q <= oe_low_i;
          end
        end
        ST_COL: begin
          if (ras_rise_i) begin
            valid_o <= 1'b1;
            type_o  <= acc_type;
            mask_o  <= lanes_q;
            st_q    <= ST_IDLE;
          end else begin
            lanes_q <= lanes_q | lanes_i;
            if (!early_q && !late_q && !rmw_q && we_low_i) begin
              if (oe_seen_q) rmw_q  <= 1'b1;
              else           late_q <= 1'b1;
            end
            if (oe_low_i && !we_low_i && cas_low_i) oe_seen_q <= 1'b1;
          end
        end
        ST_REF: begin
          if (ras_rise_i) begin
            valid_o <= 1'b1;
            type_o  <= hidden_q ? CYC_HIDDEN : CYC_CBR;
            mask_o  <= lanes_q;
            st_q    <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) st_q <= ST_SELF;
          end
        end
        ST_SELF: if (ras_rise_i) begin
          valid_o <= 1'b1;
          type_o  <= CYC_SELF;
          mask_o  <= lanes_q;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // read data held across the row-strobe rise while a column strobe stays low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      hold_q <= 1'b0;
    else if (!cas_low_i)
      hold_q <= 1'b0;
    else if (st_q == ST_COL && ras_rise_i && !early_q && !late_q && !rmw_q)
      hold_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_o <= 1'b0;
    else drive_o <= oe_low_i & ~we_low_i & cas_low_i &
                    ((st_q == ST_COL && !early_q) | hold_q);
  end
endmodule

// File: rtl/dram_ref_counter.sv
module dram_ref_counter #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (step_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/dram_cyc_decoder.sv
module dram_cyc_decoder
  import dram_cyc_pkg::*;
#(
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned SELF_CYC = 20000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             casl_ni,
  input  logic             cash_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  output logic             cyc_valid_o,
  output logic [2:0]       cyc_type_o,
  output logic [1:0]       lane_mask_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             self_ref_o,
  output logic             dq_drive_o
);
  logic             ras_fall, ras_rise, cas_low, we_low, oe_low, ref_step;
  logic [LANES-1:0] lanes, mask;
  cyc_type_e        cyc_type;

  dram_strobe_front u_front (
    .clk_i, .rst_ni, .ras_ni, .casl_ni, .cash_ni, .we_ni, .oe_ni,
    .ras_fall_o(ras_fall), .ras_rise_o(ras_rise), .cas_low_o(cas_low),
    .lanes_o(lanes), .we_low_o(we_low), .oe_low_o(oe_low)
  );

  dram_cyc_fsm #(.SELF_CYC(SELF_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .ras_fall_i(ras_fall), .ras_rise_i(ras_rise), .cas_low_i(cas_low),
    .lanes_i(lanes), .we_low_i(we_low), .oe_low_i(oe_low),
    .valid_o(cyc_valid_o), .type_o(cyc_type), .mask_o(mask),
    .ref_step_o(ref_step), .self_ref_o(self_ref_o), .drive_o(dq_drive_o)
  );

  dram_ref_counter #(.ROW_W(ROW_W)) u_ref (
    .clk_i, .rst_ni, .step_i(ref_step), .row_o(ref_row_o)
  );

  assign cyc_type_o  = cyc_type;
  assign lane_mask_o = mask;
endmodule

// File: rtl/dram_cyc_decoder_chk.sv
module dram_cyc_decoder_chk
  import dram_cyc_pkg::*;
#(
  parameter int unsigned ROW_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             cyc_valid_o,
  input logic [2:0]       cyc_type_o,
  input logic [1:0]       lane_mask_o,
  input logic [ROW_W-1:0] ref_row_o,
  input logic             self_ref_o,
  input logic             dq_drive_o
);
  logic is_ref, is_acc;
  assign is_ref = cyc_type_o == CYC_CBR || cyc_type_o == CYC_HIDDEN || cyc_type_o == CYC_SELF;
  assign is_acc = cyc_type_o <= CYC_RMW;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |=> !cyc_valid_o); // R10
  AST_REFRESH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && is_ref |-> ref_row_o == ROW_W'($past(ref_row_o) + 1'b1)); // R6
  AST_RAS_ONLY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_type_o == CYC_RAS_ONLY |-> ref_row_o == $past(ref_row_o) && lane_mask_o == 2'b00); // R5
  AST_ACCESS_KEEP_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && is_acc |-> ref_row_o == $past(ref_row_o)); // R2
  AST_EARLY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_type_o == CYC_EARLY_WR |-> !$past(dq_drive_o)); // R3
  AST_SELF_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(self_ref_o) |-> cyc_valid_o && cyc_type_o == CYC_SELF); // R8
  AST_DRIVE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_drive_o |-> $past(!oe_ni)); // R9
endmodule

bind dram_cyc_decoder dram_cyc_decoder_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni),
  .cyc_valid_o(cyc_valid_o), .cyc_type_o(cyc_type_o), .lane_mask_o(lane_mask_o),
  .ref_row_o(ref_row_o), .self_ref_o(self_ref_o), .dq_drive_o(dq_drive_o)
);

// File: tb/dram_cyc_decoder_tb.sv
`timescale 1ns/1ps
module dram_cyc_decoder_tb;
  localparam int ROW_W = 10;
  localparam int SELF_CYC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras = 1'b1, casl = 1'b1, cash = 1'b1, we = 1'b1, oe = 1'b1;
  logic valid, self_ref, dq;
  logic [2:0] ctype;
  logic [1:0] mask;
  logic [ROW_W-1:0] row;
  int n_chk = 0, n_fail = 0, exp_row = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_cyc_decoder #(.ROW_W(ROW_W), .SELF_CYC(SELF_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .casl_ni(casl), .cash_ni(cash),
    .we_ni(we), .oe_ni(oe), .cyc_valid_o(valid), .cyc_type_o(ctype),
    .lane_mask_o(mask), .ref_row_o(row), .self_ref_o(self_ref), .dq_drive_o(dq)
  );

  function automatic int next_row(input int r);
    return (r + 1) % (1 << ROW_W);
  endfunction

  function automatic int acc_code(input int kind);
    // kinds 0..3 map to codes 0..3, 4 is row-only refresh
    return kind;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic end_report(input string req, input int t, input int m);
    ras = 1'b1;
    tick();
    chk(valid == 1'b1, "R10 pulse", valid, 1);
    chk(ctype == 3'(t), req, ctype, t);
    chk(mask == 2'(m), "R11 mask", mask, m);
    chk(row == ROW_W'(exp_row), "R6 row", row, exp_row);
    tick();
    chk(valid == 1'b0, "R10 single", valid, 0);
  endtask

  task automatic access(input int kind, input logic [1:0] l);
    string req;
    req = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
    ras = 1'b0;
    tick();
    repeat ($urandom % 3) tick();
    if (kind == 1) begin we = 1'b0; tick(); end
    casl = ~l[0]; cash = ~l[1];
    if (kind == 0 || kind == 3) oe = 1'b0;
    tick();
    tick();
    if (kind == 0 || kind == 3) chk(dq == 1'b1, "R9 drive", dq, 1);
    else chk(dq == 1'b0, kind == 1 ? "R3 no drive" : "R4 no drive", dq, 0);
    repeat ($urandom % 2) tick();
    if (kind == 2 || kind == 3) begin
      we = 1'b0;
      tick();
      tick();
      chk(dq == 1'b0, "R9 we off", dq, 0);
    end
    casl = 1'b1; cash = 1'b1; we = 1'b1; oe = 1'b1;
    tick();
    end_report(req, acc_code(kind), l);
  endtask

  task automatic ras_only();
    ras = 1'b0;
    tick();
    repeat (1 + $urandom % 3) tick();
    end_report("R5", 4, 0);
  endtask

  task automatic cbr(input logic [1:0] l, input int nlow);
    bit exp_self;
    exp_self = (nlow > SELF_CYC);
    casl = ~l[0]; cash = ~l[1];
    tick();
    ras = 1'b0;
    tick();
    repeat (nlow - 1) tick();
    chk(self_ref == exp_self, "R8 self", self_ref, exp_self);
    exp_row = next_row(exp_row);
    end_report(exp_self ? "R8" : "R6", exp_self ? 7 : 5, l);
    if (exp_row == 0) chk(row == '0, "R12 wrap", row, 0);
    casl = 1'b1; cash = 1'b1;
    tick();
  endtask

  task automatic hidden(input logic [1:0] l);
    ras = 1'b0;
    tick();
    casl = ~l[0]; cash = ~l[1]; oe = 1'b0;
    tick(); tick(); tick();
    chk(dq == 1'b1, "R9 read drive", dq, 1);
    end_report("R2", 0, l);
    chk(dq == 1'b1, "R9 held", dq, 1);
    ras = 1'b0;
    tick(); tick();
    chk(dq == 1'b1, "R7 drive in refresh", dq, 1);
    exp_row = next_row(exp_row);
    end_report("R7", 6, l);
    chk(dq == 1'b1, "R7 drive after", dq, 1);
    casl = 1'b1; cash = 1'b1; oe = 1'b1;
    tick(); tick();
    chk(dq == 1'b0, "R9 cleared", dq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(row == '0, "R1 row", row, 0);
    chk(self_ref == 1'b0, "R1 self", self_ref, 0);
    chk(dq == 1'b0, "R1 drive", dq, 0);

    for (int i = 0; i < 150; i++) begin
      int kind;
      logic [1:0] l;
      kind = $urandom % 6;
      l = 2'(1 + $urandom % 3);
      if (kind < 4) access(kind, l);
      else if (kind == 4) ras_only();
      else cbr(l, 1 + $urandom % SELF_CYC);
    end

    cbr(2'b01, SELF_CYC);
    cbr(2'b10, SELF_CYC + 1);
    cbr(2'b11, SELF_CYC + 5);
    hidden(2'b11);
    hidden(2'b01);
    access(1, 2'b10);
    access(3, 2'b01);
    access(2, 2'b11);
    ras_only();

    for (int i = 0; i < 1024; i++) cbr(2'b01, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule